// File: doc/BRIEF.md
# Periodic Tick-Rate Interrupt Generator

This block divides a 32.768 kHz tick, delivered as a one-cycle enable in the system clock domain, down to a periodic event. A 4-bit rate code sets the period, and a 3-bit chain-control field runs the counter, freezes it, or holds it cleared. Each period expiry sets a status flag. That flag, gated by an enable bit, drives a single interrupt request line.

Software reaches three byte-wide registers over a simple read/write strobe interface. The register addresses are:

- Mode register (address 0): rate code in bits 3:0, chain control in bits 6:4, and bit 7 reserved as a read-only busy flag.
- Enable register (address 1): periodic interrupt enable in bit 6.
- Status register (address 2): read-only. Bit 6 is the periodic flag and bit 7 is the request summary.

Address 3 reads as zero.

The chain-control FSM has three states:

- `ST_IDLE`: counter held at zero. This is the reset state, and the FSM enters it for any chain value other than 2 or 6.
- `ST_RUN`: counting enabled, entered for chain value 2.
- `ST_HALT`: counter frozen, entered for chain value 6.

Its transitions are:

- start (`ST_IDLE` to `ST_RUN`) and park (`ST_IDLE` to `ST_HALT`).
- freeze (`ST_RUN` to `ST_HALT`) and drop (`ST_RUN` to `ST_IDLE`).
- resume (`ST_HALT` to `ST_RUN`) and release (`ST_HALT` to `ST_IDLE`). Both restart the counter.

The FSM follows the stored chain field one clock after the register write.

Top module: `pig_top`

## Requirements
- R1: After reset all three registers read 0x00 and `irq` is low (rate code 0, chain value 0, all status clear).
- R2: For rate codes 3 to 15 the periodic event comes every 2^(code-1) ticks while counting, e.g. code 3 every 4 ticks, code 7 every 64, code 15 every 16384.
- R3: Rate code 1 gives a 128-tick period and code 2 a 256-tick period.
- R4: Rate code 0 produces no periodic event.
- R5: Chain value 2 (mode bits 6:4) counts ticks. Value 6 freezes the count, and no event occurs while frozen. Any other value, including 0, holds the count at zero.
- R6: A mode write that changes the rate code, or leaving the halt state, restarts the count from zero, so the next event comes one full period later.
- R7: Mode bit 7 always reads 0; writing it has no effect on any mode bit.
- R8: Status bit 6 sets on every period expiry whether or not enable bit 6 is set.
- R9: Status bit 7 and `irq` are high exactly when status bit 6 and enable bit 6 are both set.
- R10: Writes to the status register are ignored; a read of the status register returns its contents and clears the whole register afterwards.
- R11: When an expiry falls in the same cycle as a status read, that read returns the prior value and the flag is left set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_32k | input | 1 | One-cycle enable per 32.768 kHz tick |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (status clears on it) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, valid while it is held |
| irq | output | 1 | Periodic interrupt request |

## Verification
Two functions can fall in the same cycle: the counter's expiry, which sets the periodic flag, and the clear-on-read of the status register. The bench provokes this with the 4-tick rate. It brings the count to three ticks, then drives the fourth tick in the same cycle as a status read. The read must return 0x00, and a following read must return 0xC0, which shows that the set won over the clear. The halt-exit and rate-change restarts are judged by reading status one tick short of a full period after the restart, where a stale count would already have expired.

// File: rtl/pig_pkg.sv
package pig_pkg;

    localparam int RATE_W  = 4;
    localparam int CHAIN_W = 3;
    localparam int ADDR_W  = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } chain_state_e;

    localparam logic [CHAIN_W-1:0] CHAIN_RUN  = 3'd2;
    localparam logic [CHAIN_W-1:0] CHAIN_HALT = 3'd6;

    localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_EN   = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

    localparam int EN_BIT   = 6;
    localparam int FLAG_BIT = 6;
    localparam int REQ_BIT  = 7;

endpackage

// File: rtl/pig_ctrl.sv
module pig_ctrl
    import pig_pkg::*;
#(
    parameter int CW = CHAIN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] chain,
    output logic          count_en,
    output logic          hold_zero,
    output logic          resume
);

    chain_state_e state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (chain == CHAIN_RUN)       state_nxt = ST_RUN;   // start
                else if (chain == CHAIN_HALT) state_nxt = ST_HALT;  // park
            end
            ST_RUN: begin
                if (chain == CHAIN_HALT)      state_nxt = ST_HALT;  // freeze
                else if (chain != CHAIN_RUN)  state_nxt = ST_IDLE;  // drop
            end
            ST_HALT: begin
                if (chain == CHAIN_RUN)       state_nxt = ST_RUN;   // resume
                else if (chain != CHAIN_HALT) state_nxt = ST_IDLE;  // release
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        count_en  = (state == ST_RUN);
        hold_zero = (state == ST_IDLE);
        resume    = (state == ST_HALT) && (state_nxt != ST_HALT);
    end

    // R5: a value other than run or halt parks the FSM in idle
    a_r5_other_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (chain != CHAIN_RUN && chain != CHAIN_HALT) |=> (state == ST_IDLE));

    // R6: leaving halt for run lands in the run state
    a_r6_halt_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && chain == CHAIN_RUN) |=> (state == ST_RUN));

endmodule

// File: rtl/pig_divider.sv
module pig_divider
    import pig_pkg::*;
#(
    parameter int RW = RATE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [RW-1:0] rate,
    input  logic          count_en,
    input  logic          hold_zero,
    input  logic          restart,
    output logic          expire
);

    localparam int NCODES = 1 << RW;
    localparam int CNT_W  = NCODES - 2;

    logic [CNT_W-1:0] last_tbl [NCODES];
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    logic             step;

    for (genvar g = 0; g < NCODES; g++) begin : g_period
        localparam int LAST = (g == 0) ? 0 :
                              (g <= 2) ? ((1 << (g + 6)) - 1) :
                                         ((1 << (g - 1)) - 1);
        assign last_tbl[g] = CNT_W'(LAST);
    end

    assign last   = last_tbl[rate];
    assign step   = count_en && tick && (rate != '0) && !restart;
    assign expire = step && (cnt == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (restart || hold_zero) cnt <= '0;
        else if (step)              cnt <= (cnt == last) ? '0 : cnt + 1'b1;
    end

    // R2: the count never passes the last value of the selected period
    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last);

    // R4: code 0 never expires
    a_r4_code0_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (rate == '0) |-> !expire);

    // R5: without run, idle or restart the count is frozen
    a_r5_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !hold_zero && !restart) |=> $stable(cnt));

endmodule

// File: rtl/pig_regs.sv
module pig_regs
    import pig_pkg::*;
#(
    parameter int RW = RATE_W,
    parameter int CW = CHAIN_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [RW+CW:0] bus_wdata,
    input  logic          expire,
    output logic [RW+CW:0] bus_rdata,
    output logic [RW-1:0] rate,
    output logic [CW-1:0] chain,
    output logic          rate_chg,
    output logic          irq
);

    localparam int DW = RW + CW + 1;

    logic en_q, flag_q, req;
    logic wr_mode, wr_en, rd_stat;

    assign wr_mode  = bus_wr && (bus_addr == ADDR_MODE);
    assign wr_en    = bus_wr && (bus_addr == ADDR_EN);
    assign rd_stat  = bus_rd && (bus_addr == ADDR_STAT);
    assign rate_chg = wr_mode && (bus_wdata[RW-1:0] != rate);
    assign req      = flag_q && en_q;
    assign irq      = req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate  <= '0;
            chain <= '0;
            en_q  <= 1'b0;
        end else begin
            if (wr_mode) begin
                rate  <= bus_wdata[RW-1:0];
                chain <= bus_wdata[RW+CW-1:RW];
            end
            if (wr_en) en_q <= bus_wdata[EN_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (expire)  flag_q <= 1'b1;
        else if (rd_stat) flag_q <= 1'b0;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_MODE: bus_rdata = {1'b0, chain, rate};
            ADDR_EN:   bus_rdata[EN_BIT] = en_q;
            ADDR_STAT: begin
                bus_rdata[FLAG_BIT] = flag_q;
                bus_rdata[REQ_BIT]  = req;
            end
            default:   bus_rdata = {DW{1'b0}};
        endcase
    end

    // R8: an expiry always leaves the flag set
    a_r8_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag_q);

    // R10: a status read with no coincident expiry clears the flag
    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !expire) |=> !flag_q);

endmodule

// File: rtl/pig_top.sv
module pig_top
    import pig_pkg::*;
#(
    parameter int RW = RATE_W,
    parameter int CW = CHAIN_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_32k,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [RW+CW:0] bus_wdata,
    output logic [RW+CW:0] bus_rdata,
    output logic          irq
);

    logic [RW-1:0] rate;
    logic [CW-1:0] chain;
    logic rate_chg, count_en, hold_zero, resume, expire;

    pig_regs #(.RW(RW), .CW(CW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .expire(expire), .bus_rdata(bus_rdata),
        .rate(rate), .chain(chain), .rate_chg(rate_chg), .irq(irq)
    );

    pig_ctrl #(.CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .chain(chain),
        .count_en(count_en), .hold_zero(hold_zero), .resume(resume)
    );

    pig_divider #(.RW(RW)) u_div (
        .clk(clk), .rst_n(rst_n), .tick(tick_32k), .rate(rate),
        .count_en(count_en), .hold_zero(hold_zero),
        .restart(resume || rate_chg), .expire(expire)
    );

endmodule

// File: tb/pig_top_bench.sv
module pig_top_bench;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_32k = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    pig_top u_pig_top (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // monitor: pops expected read data and compares
    always @(negedge clk) begin
        if (bus_rd && rst_n) begin
            logic [7:0] e;
            string t;
            compared++;
            if (exp_q.size() == 0) begin
                mismatched++;
                $display("FAIL scoreboard underflow: actual %02h expected none", bus_rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    mismatched++;
                    $display("FAIL %s: actual %02h expected %02h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        @(posedge clk); #1;
        @(posedge clk); #1;
    endtask

    task automatic bus_read(input logic [1:0] a, input logic [7:0] e,
                            input string tag, input bit with_tick = 1'b0);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_addr = a; bus_rd = 1'b1; tick_32k = with_tick;
        @(posedge clk); #1;
        bus_rd = 1'b0; tick_32k = 1'b0;
    endtask

    task automatic give_ticks(input int n);
        if (n > 0) begin
            tick_32k = 1'b1;
            repeat (n) @(posedge clk);
            #1 tick_32k = 1'b0;
        end
    endtask

    task automatic check_irq(input logic e, input string tag);
        compared++;
        if (irq !== e) begin
            mismatched++;
            $display("FAIL %s: irq actual %0b expected %0b", tag, irq, e);
        end
    endtask

    // checks one full period of length p from a restarted count
    task automatic period_check(input int p, input string tag);
        give_ticks(p - 1);
        bus_read(2'd2, 8'h00, {tag, " early"});
        give_ticks(1);
        check_irq(1'b1, {tag, " irq"});
        bus_read(2'd2, 8'hC0, {tag, " expiry"});
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        check_irq(1'b0, "R1 reset irq");
        bus_read(2'd0, 8'h00, "R1 mode reset");
        bus_read(2'd1, 8'h00, "R1 enable reset");
        bus_read(2'd2, 8'h00, "R1 status reset");

        // R2 code 3, enable on
        bus_write(2'd0, 8'h23);
        bus_write(2'd1, 8'h40);
        bus_read(2'd0, 8'h23, "R2 mode readback");
        period_check(4, "R2 code3");
        bus_read(2'd2, 8'h00, "R10 cleared after read");
        check_irq(1'b0, "R9 irq drops after read");

        // R2 codes 7 and 15
        bus_write(2'd0, 8'h27);
        period_check(64, "R2 code7");
        bus_write(2'd0, 8'h2F);
        period_check(16384, "R2 code15");

        // R3 aliases
        bus_write(2'd0, 8'h21);
        period_check(128, "R3 code1");
        bus_write(2'd0, 8'h22);
        period_check(256, "R3 code2");

        // R8/R9 enable off
        bus_write(2'd1, 8'h00);
        bus_write(2'd0, 8'h23);
        give_ticks(4);
        check_irq(1'b0, "R9 irq masked");
        bus_read(2'd2, 8'h40, "R8 flag without enable");
        bus_read(2'd1, 8'h00, "R9 enable readback");

        // R4 code 0
        bus_write(2'd0, 8'h20);
        give_ticks(300);
        bus_read(2'd2, 8'h00, "R4 code0 silent");

        // R5 halt, R6 restart on leaving halt
        bus_write(2'd1, 8'h40);
        bus_write(2'd0, 8'h23);
        give_ticks(2);
        bus_write(2'd0, 8'h63);
        give_ticks(10);
        bus_read(2'd2, 8'h00, "R5 halt frozen");
        bus_write(2'd0, 8'h23);
        period_check(4, "R6 halt exit");

        // R5 uninitialised holds zero
        bus_write(2'd0, 8'h03);
        give_ticks(10);
        bus_read(2'd2, 8'h00, "R5 chain0 held");
        bus_write(2'd0, 8'h23);
        period_check(4, "R5 chain0 to run");

        // R6 rate change mid count
        bus_write(2'd0, 8'h27);
        give_ticks(40);
        bus_write(2'd0, 8'h23);
        period_check(4, "R6 rate change");

        // R7 bit 7 ignored
        bus_write(2'd0, 8'hA3);
        bus_read(2'd0, 8'h23, "R7 busy bit");

        // R10 writes to status ignored
        give_ticks(4);
        bus_write(2'd2, 8'h00);
        bus_read(2'd2, 8'hC0, "R10 write ignored");

        // R11 expiry coincides with status read
        give_ticks(3);
        bus_read(2'd2, 8'h00, "R11 coincident read", 1'b1);
        check_irq(1'b1, "R11 irq kept");
        bus_read(2'd2, 8'hC0, "R11 flag kept");

        @(posedge clk); #1;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule